// File: doc/BRIEF.md
# I2C Command-Bit Bus Master

This block is an I2C bus master that software drives one bus phase at a time. A 16-bit control register holds five one-shot command bits: Start, Repeated Start, Stop, byte receive and Acknowledge. Writing one of them launches the matching bus sequence. The bit reads back as 1 while that sequence runs, and the hardware clears it when the sequence finishes. A byte is transmitted by writing the data buffer while the master owns the bus and no sequence is running. The slave's answer on the ninth clock is then kept in an acknowledge-status bit.

SCL and SDA are open-drain, so the block only outputs pull-low enables. Every bit period is four quarters, and each quarter lasts `quarter_div + 1` clock cycles. While any sequence is active, control and buffer writes are dropped entirely and no request is held for later. A `busy` level and a one-cycle `done` pulse frame every sequence.

Top module: `i2c_cmd_master`

## Requirements
- R1: During and after reset, `ctrl_rdata`, `rx_data`, `scl_oe`, `sda_oe`, `busy` and `done` are all 0.
- R2: Control bit 0 (Start) is accepted only when the bus is free. Its four quarters drive SCL/SDA pull-low as released/released, released/low, released/low, low/low. Bit 0 reads 1 during the sequence and 0 afterwards, and the master then owns the bus.
- R3: Control bit 1 (Repeated Start) is accepted only when the bus is owned. Its quarters are low/released, released/released, released/low, low/low, with the bit reading 1 until completion.
- R4: Control bit 2 (Stop) is accepted only when the bus is owned. Its quarters are low/low, released/low, released/released, released/released. Afterwards both lines are released and bit 2 reads 0.
- R5: A buffer write while the bus is owned and idle sends 9 bit slots. The first 8 carry the byte MSB first, with SDA pulled low for a 0. The ninth leaves SDA released. In every slot SCL is low in quarters 0 and 3 and released in quarters 1 and 2, and SDA changes only while SCL is low.
- R6: Control bit 6 takes the SDA level sampled at the end of quarter 1 of the ninth slot: 0 if the slave acknowledged and 1 if it did not. It changes at that point and holds until the next transmission.
- R7: Control bit 3 (receive) is accepted only when the bus is owned. It clocks 8 slots with SDA released, samples SDA at the end of each slot's quarter 1 (MSB first), and presents the byte on `rx_data` at completion.
- R8: Control bit 4 (Acknowledge) is accepted only when the bus is owned. It clocks one slot that pulls SDA low if control bit 5 is 0 (ACK) and releases it if bit 5 is 1 (NACK). A control write that sets bit 4 also sets bit 5 from the same write.
- R9: While `busy` is 1, control writes and buffer writes have no effect: readback bits, bus waveform and sequence length are unchanged, and nothing runs afterwards.
- R10: Bits 15..7 read 0. A control write with more than one of bits 4..0 set launches nothing. A buffer write while the bus is free launches nothing.
- R11: `busy` is 1 exactly for the duration of a sequence, which is slots × 4 × (`quarter_div`+1) cycles. `done` pulses for one cycle right after it. Between sequences the master holds SCL low while it owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_div | input | DIV_W | Cycles per quarter bit period minus one |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write data |
| ctrl_rdata | output | 16 | Control register readback |
| buf_wr | input | 1 | Data buffer write strobe (starts a transmission) |
| buf_wdata | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A bus sequence is running |
| done | output | 1 | One-cycle pulse after a sequence ends |

## Verification
Bad internal state can show up at the ports in several ways. A quarter or slot counter that is off by one moves an SCL or SDA edge, and that is visible in the very cycle the edge is due. A shift register that shifts at the wrong point puts a bad bit on SDA within one quarter. A lost ownership flag or lockout flag makes the design accept or refuse the next command, which changes the readback bits the cycle after the write. The reference model predicts `scl_oe`, `sda_oe`, `busy`, `done` and the full readback for every cycle, so each of these faults is reported no later than the cycle it first appears.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned CMD_W  = 5;
  localparam int unsigned SLOT_W = $clog2(BYTE_W + 2);

  localparam int unsigned B_START   = 0;
  localparam int unsigned B_RSTART  = 1;
  localparam int unsigned B_STOP    = 2;
  localparam int unsigned B_RX      = 3;
  localparam int unsigned B_ACK     = 4;
  localparam int unsigned B_ACKVAL  = 5;
  localparam int unsigned B_ACKSTAT = 6;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_RSTART, SQ_STOP, SQ_TX, SQ_RX, SQ_ACK
  } seq_e;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!run)            cnt_n = '0;
    else if (cnt_q == div) cnt_n = '0;
    else                 cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = run && (cnt_q == div);
endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  seq_e              launch_kind,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              ack_val,
  input  logic              sda_in,
  output logic              busy,
  output logic              owned,
  output logic              finish,
  output logic              done,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ack_stat,
  output logic [BYTE_W-1:0] rx_byte
);
  seq_e              kind_q, kind_n;
  logic [1:0]        qtr_q, qtr_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [BYTE_W-1:0] sh_q, sh_n, rx_q, rx_n;
  logic              busy_q, busy_n, own_q, own_n, ack_q, ack_n;
  logic              scl_q, scl_n, sda_q, sda_n, done_q;
  logic [1:0]        pat;

  function automatic logic [SLOT_W-1:0] slot_last(input seq_e k);
    case (k)
      SQ_TX:   return SLOT_W'(BYTE_W);
      SQ_RX:   return SLOT_W'(BYTE_W - 1);
      default: return '0;
    endcase
  endfunction

  // returns {scl_low, sda_low} for one quarter
  function automatic logic [1:0] drive_pat(input seq_e k, input logic [1:0] q,
                                           input logic [SLOT_W-1:0] s,
                                           input logic msb, input logic av);
    logic d;
    case (k)
      SQ_START:  case (q) 2'd0: return 2'b00; 2'd1, 2'd2: return 2'b01; default: return 2'b11; endcase
      SQ_RSTART: case (q) 2'd0: return 2'b10; 2'd1: return 2'b00; 2'd2: return 2'b01; default: return 2'b11; endcase
      SQ_STOP:   case (q) 2'd0: return 2'b11; 2'd1: return 2'b01; default: return 2'b00; endcase
      default: begin
        if (k == SQ_TX)      d = (s < SLOT_W'(BYTE_W)) ? ~msb : 1'b0;
        else if (k == SQ_RX) d = 1'b0;
        else                 d = ~av;
        return {(q == 2'd0) || (q == 2'd3), d};
      end
    endcase
  endfunction

  always_comb begin
    kind_n = kind_q; qtr_n = qtr_q; slot_n = slot_q; sh_n = sh_q;
    busy_n = busy_q; own_n = own_q; ack_n = ack_q; rx_n = rx_q;
    finish = 1'b0;
    if (launch) begin
      kind_n = launch_kind;
      qtr_n  = 2'd0;
      slot_n = '0;
      busy_n = 1'b1;
      if (launch_kind == SQ_TX) sh_n = tx_byte;
    end else if (busy_q && tick) begin
      if (qtr_q == 2'd1) begin
        if (kind_q == SQ_RX) sh_n = {sh_q[BYTE_W-2:0], sda_in};
        if (kind_q == SQ_TX && slot_q == SLOT_W'(BYTE_W)) ack_n = sda_in;
      end
      if (qtr_q == 2'd3) begin
        qtr_n = 2'd0;
        if (slot_q == slot_last(kind_q)) begin
          finish = 1'b1;
          busy_n = 1'b0;
          kind_n = SQ_IDLE;
          slot_n = '0;
          if (kind_q == SQ_START || kind_q == SQ_RSTART) own_n = 1'b1;
          if (kind_q == SQ_STOP) own_n = 1'b0;
          if (kind_q == SQ_RX)   rx_n  = sh_q;
        end else begin
          slot_n = slot_q + SLOT_W'(1);
          if (kind_q == SQ_TX) sh_n = {sh_q[BYTE_W-2:0], 1'b0};
        end
      end else begin
        qtr_n = qtr_q + 2'd1;
      end
    end
    pat = drive_pat(kind_n, qtr_n, slot_n, sh_n[BYTE_W-1], ack_val);
    if (busy_n)     begin scl_n = pat[1]; sda_n = pat[0]; end
    else if (own_n) begin scl_n = 1'b1;   sda_n = sda_q;  end
    else            begin scl_n = 1'b0;   sda_n = 1'b0;   end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SQ_IDLE; qtr_q <= 2'd0; slot_q <= '0; sh_q <= '0; rx_q <= '0;
      busy_q <= 1'b0; own_q <= 1'b0; ack_q <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0; done_q <= 1'b0;
    end else begin
      kind_q <= kind_n; qtr_q <= qtr_n; slot_q <= slot_n; sh_q <= sh_n; rx_q <= rx_n;
      busy_q <= busy_n; own_q <= own_n; ack_q <= ack_n;
      scl_q <= scl_n; sda_q <= sda_n; done_q <= finish;
    end
  end

  assign busy     = busy_q;
  assign owned    = own_q;
  assign done     = done_q;
  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign ack_stat = ack_q;
  assign rx_byte  = rx_q;

  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !scl_q && $past(!scl_q) && (sda_q != $past(sda_q)))
      |-> (kind_q == SQ_START || kind_q == SQ_RSTART || kind_q == SQ_STOP));
  // R4
  free_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !own_q) |-> (!scl_q && !sda_q));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              buf_wr,
  input  logic              busy,
  input  logic              owned,
  input  logic              finish,
  input  logic              ack_stat,
  output logic              launch,
  output seq_e              launch_kind,
  output logic              ack_val_eff,
  output logic [CTRL_W-1:0] ctrl_rdata
);
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic             av_q, av_n, legal;
  logic             unused_hi;

  assign unused_hi = ^ctrl_wdata[CTRL_W-1:B_ACKVAL+1];

  always_comb begin
    cmd_n = cmd_q;
    av_n  = av_q;
    launch = 1'b0;
    launch_kind = SQ_IDLE;
    legal = 1'b0;
    if (finish) cmd_n = '0;
    if (!busy) begin
      if (ctrl_wr) begin
        av_n = ctrl_wdata[B_ACKVAL];
        if ($onehot(ctrl_wdata[CMD_W-1:0])) begin
          case (1'b1)
            ctrl_wdata[B_START]:  begin launch_kind = SQ_START;  legal = !owned; end
            ctrl_wdata[B_RSTART]: begin launch_kind = SQ_RSTART; legal = owned;  end
            ctrl_wdata[B_STOP]:   begin launch_kind = SQ_STOP;   legal = owned;  end
            ctrl_wdata[B_RX]:     begin launch_kind = SQ_RX;     legal = owned;  end
            default:              begin launch_kind = SQ_ACK;    legal = owned;  end
          endcase
          if (legal) begin
            launch = 1'b1;
            cmd_n  = ctrl_wdata[CMD_W-1:0];
          end
        end
      end else if (buf_wr && owned) begin
        launch = 1'b1;
        launch_kind = SQ_TX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      av_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_n;
      av_q  <= av_n;
    end
  end

  assign ack_val_eff = (!busy && ctrl_wr) ? ctrl_wdata[B_ACKVAL] : av_q;

  always_comb begin
    ctrl_rdata = '0;
    ctrl_rdata[CMD_W-1:0] = cmd_q;
    ctrl_rdata[B_ACKVAL]  = av_q;
    ctrl_rdata[B_ACKSTAT] = ack_stat;
  end

  // R9
  locked_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> ($stable(cmd_q) && $stable(av_q)));
  // R10
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_q));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             ctrl_wr,
  input  logic [15:0]      ctrl_wdata,
  output logic [15:0]      ctrl_rdata,
  input  logic             buf_wr,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       rx_data,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick, launch, owned, finish, ack_val_eff, ack_stat;
  seq_e       launch_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk(clk), .rst_n(rst_int_n), .run(busy), .div(quarter_div), .tick(tick)
  );

  i2c_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .buf_wr(buf_wr), .busy(busy), .owned(owned), .finish(finish),
    .ack_stat(ack_stat), .launch(launch), .launch_kind(launch_kind),
    .ack_val_eff(ack_val_eff), .ctrl_rdata(ctrl_rdata)
  );

  i2c_seq_engine u_engine (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .launch(launch),
    .launch_kind(launch_kind), .tx_byte(buf_wdata), .ack_val(ack_val_eff),
    .sda_in(sda_in), .busy(busy), .owned(owned), .finish(finish), .done(done),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ack_stat(ack_stat), .rx_byte(rx_data)
  );
endmodule

// File: tb/i2c_cmd_master_test.sv
`timescale 1ns/1ps
module i2c_cmd_master_test;
  typedef struct {
    bit          busy;
    bit          done;
    bit          scl;
    bit          sda;
    logic [15:0] ctrl;
    bit          slave;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  quarter_div = 8'd2;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        buf_wr = 1'b0;
  logic [7:0]  buf_wdata = '0;
  logic [7:0]  rx_data;
  logic        scl_oe, sda_oe, busy, done;
  logic        slave_low = 1'b0;
  logic        sda_in;

  int vectors = 0, fails = 0, cyc = 0;
  bit cmp_on = 0;
  int div_m = 2;
  bit owned_m = 0, last_sda_m = 0, ack_stat_m = 0, ack_val_m = 0;
  exp_t q[$];

  assign sda_in = ~(sda_oe | slave_low);

  i2c_cmd_master uut (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .rx_data(rx_data), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R11 watchdog: actual hung, expected completion");
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (cmp_on) begin
      exp_t e;
      if (q.size() != 0) e = q.pop_front();
      else begin
        e.busy = 0; e.done = 0; e.scl = owned_m; e.sda = owned_m ? last_sda_m : 1'b0;
        e.ctrl = {9'b0, ack_stat_m, ack_val_m, 5'b0}; e.slave = 0; e.tag = "R11 idle";
      end
      slave_low = e.slave;
      check(e.tag, {8'b0, busy, done, scl_oe, sda_oe, ctrl_rdata},
                   {8'b0, e.busy, e.done, e.scl, e.sda, e.ctrl});
    end
  end

  // kind: 0 start, 1 rstart, 2 stop, 3 tx, 4 rx, 5 ack
  task automatic push_seq(input int kind, input logic [7:0] b, input bit sl_ack, input string tag);
    int nslot, ql, quarter, s, qq;
    bit sc, sd, new_ack, as;
    logic [4:0] cmdb;
    exp_t e;
    nslot = (kind == 3) ? 9 : (kind == 4) ? 8 : 1;
    ql = div_m + 1;
    cmdb = (kind == 0) ? 5'd1 : (kind == 1) ? 5'd2 : (kind == 2) ? 5'd4 :
           (kind == 4) ? 5'd8 : (kind == 5) ? 5'd16 : 5'd0;
    new_ack = !sl_ack;
    sd = 0;
    for (int i = 0; i < nslot * 4 * ql; i++) begin
      quarter = i / ql; s = quarter / 4; qq = quarter % 4;
      case (kind)
        0: begin sc = (qq == 3); sd = (qq != 0); end
        1: begin sc = (qq == 0 || qq == 3); sd = (qq >= 2); end
        2: begin sc = (qq == 0); sd = (qq <= 1); end
        default: begin
          sc = (qq == 0 || qq == 3);
          if (kind == 3)      sd = (s < 8) ? !b[7 - s] : 1'b0;
          else if (kind == 4) sd = 1'b0;
          else                sd = !ack_val_m;
        end
      endcase
      as = (kind == 3 && i >= 34 * ql) ? new_ack : ack_stat_m;
      e.busy = 1; e.done = 0; e.scl = sc; e.sda = sd;
      e.ctrl = {9'b0, as, ack_val_m, cmdb};
      e.slave = (kind == 3 && s == 8) ? sl_ack : (kind == 4) ? !b[7 - s] : 1'b0;
      e.tag = tag;
      q.push_back(e);
    end
    if (kind == 3) ack_stat_m = new_ack;
    if (kind == 0 || kind == 1) owned_m = 1;
    if (kind == 2) owned_m = 0;
    last_sda_m = sd;
    e.busy = 0; e.done = 1; e.scl = owned_m; e.sda = owned_m ? last_sda_m : 1'b0;
    e.ctrl = {9'b0, ack_stat_m, ack_val_m, 5'b0}; e.slave = 0; e.tag = {tag, " done R11"};
    q.push_back(e);
  endtask

  task automatic wr_ctrl(input logic [15:0] d);
    @(posedge clk); #1 ctrl_wr = 1; ctrl_wdata = d;
    @(posedge clk); #1 ctrl_wr = 0;
  endtask

  task automatic wr_buf(input logic [7:0] d);
    @(posedge clk); #1 buf_wr = 1; buf_wdata = d;
    @(posedge clk); #1 buf_wr = 0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic do_cmd(input logic [15:0] d, input int kind, input logic [7:0] b, input string tag);
    wr_ctrl(d);
    ack_val_m = d[5];
    push_seq(kind, b, 1'b0, tag);
    wait_idle();
  endtask

  task automatic do_tx(input logic [7:0] b, input bit sl_ack, input string tag);
    wr_buf(b);
    push_seq(3, b, sl_ack, tag);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, done, scl_oe, sda_oe}, 4'b0);
    check("R1 reset ctrl", ctrl_rdata, 16'h0000);
    check("R1 reset rx", rx_data, 8'h00);
    @(posedge clk); #1 rst_n = 1;
    cmp_on = 1;
    repeat (4) @(posedge clk);

    do_cmd(16'h0001, 0, 8'h00, "R2 start");
    do_tx(8'hA5, 1'b1, "R5 tx A5 R6 ack");
    wait_idle();
    check("R6 ack status ack", ctrl_rdata[6], 1'b0);

    do_tx(8'h3C, 1'b0, "R5 tx 3C R6 nack");
    repeat (20) @(posedge clk);
    wr_ctrl(16'h0024);        // R9: stop + ack value while busy, must be dropped
    wr_buf(8'hFF);            // R9: buffer write while busy, must be dropped
    wr_ctrl(16'h0008);        // R9
    wait_idle();
    check("R6 ack status nack", ctrl_rdata[6], 1'b1);
    check("R9 no queued sequence", busy, 1'b0);

    do_cmd(16'h0008, 4, 8'h96, "R7 rx 96");
    check("R7 rx data 96", rx_data, 8'h96);
    do_cmd(16'h0010, 5, 8'h00, "R8 ack");
    do_cmd(16'h0008, 4, 8'h5B, "R7 rx 5B");
    check("R7 rx data 5B", rx_data, 8'h5B);
    do_cmd(16'h0030, 5, 8'h00, "R8 nack");

    // R10: rejected requests; comparator checks nothing starts
    wr_ctrl(16'h0006); ack_val_m = 0;
    wr_ctrl(16'h0001);        // start while owned
    wr_ctrl(16'hFFA0); ack_val_m = 1;
    repeat (3) @(negedge clk);
    check("R10 upper bits zero", ctrl_rdata[15:7], 9'h000);
    check("R10 nothing launched", busy, 1'b0);
    wr_ctrl(16'h0000); ack_val_m = 0;

    do_cmd(16'h0002, 1, 8'h00, "R3 rstart");
    @(posedge clk); #1 quarter_div = 8'd0; div_m = 0;
    do_tx(8'h01, 1'b1, "R5 tx 01 div0");
    wait_idle();
    check("R6 ack after div0", ctrl_rdata[6], 1'b0);
    do_cmd(16'h0004, 2, 8'h00, "R4 stop");
    check("R4 lines released", {scl_oe, sda_oe}, 2'b00);

    // R10: free bus, buffer write and receive must not start
    wr_buf(8'h55);
    wr_ctrl(16'h0008);
    repeat (4) @(negedge clk);
    check("R10 free bus ignored", busy, 1'b0);

    @(posedge clk); #1 quarter_div = 8'd1; div_m = 1;
    do_cmd(16'h0001, 0, 8'h00, "R2 start div1");
    do_cmd(16'h0004, 2, 8'h00, "R4 stop div1");
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule